// File: doc/BRIEF.md
# Display-List Fetch Address Sequencer

This block produces the fetch address for a display-list coprocessor that runs once per video frame. It keeps a start pointer, a jump pointer and a 3-bit memory bank, and presents a 19-bit address made of the bank above a 16-bit word address. The pointers are loaded through byte writes, which come either from the host CPU or from the coprocessor's own register-move instruction. When the list is enabled, each frame-start pulse restarts fetching from the start pointer inside whichever bank is selected at that moment.

Writing the jump strobe sends execution to the jump pointer on the next cycle. It behaves as a plain jump and not as a second list, so the next frame begins at the start pointer again. The value written to the jump strobe can also move the sequencer to another bank, and that bank stays selected across later frame restarts. Software that leaves the original bank therefore has to switch back before the frame ends. Beyond this, the sequencer steps forward by 1 to 3 words after each instruction, takes signed relative branches, and stops at an end-of-list command until the next frame start.

The control core is a two-state machine. In ST_HALT nothing is fetched. In ST_RUN fetching is live. The transitions are T_START (ST_HALT to ST_RUN on a frame start with the list enabled), T_RESTART (ST_RUN to ST_RUN on a frame start with the list enabled), T_STOP (ST_RUN to ST_HALT on an end-of-list command) and T_DISABLE (either state to ST_HALT on a frame start with the list disabled). Every other cycle keeps the current state, and the pointer actions then run in that state.

Top module: `dlist_seq`

## Requirements
- R1: After reset the sequencer is halted (`running`=0), `fetch_addr` is 0, the bank is 0 and both pointers are 0.
- R2: A `frame_start` pulse while `list_en`=1 gives `running`=1 on the following cycle, with `fetch_addr` equal to {current bank, start pointer}. The start pointer low byte is at register offset 0x3E and its high byte at 0x3F.
- R3: While running, an `advance` pulse adds `adv_words` (0 to 3) to the 16-bit word address. The sum wraps modulo 65536 and the bank is left unchanged.
- R4: While running, a `branch` pulse adds the sign-extended 8-bit `branch_off` (two's complement) to the word address.
- R5: The jump pointer low byte is at offset 0x41 and its high byte at 0x42. Any write to the jump strobe at offset 0x43 loads the word address from the jump pointer, and the result shows on `fetch_addr` in the next cycle.
- R6: In the jump strobe value, bit 3 set means the bank becomes bits 2..0 in the same cycle the jump pointer is loaded. Bit 3 clear leaves the bank unchanged.
- R7: A write to the start strobe at offset 0x40 loads the word address from the start pointer. It never changes the bank, whatever value is written.
- R8: The frame-start restart does not reset the bank. After a jump, the next frame starts from the start pointer in the bank that is currently selected.
- R9: An `end_list` pulse while running halts the sequencer. While halted, `advance` and `branch` leave `fetch_addr` unchanged.
- R10: When a strobe write and a `frame_start` fall in the same cycle, the frame restart wins. The strobe has no effect on the address or the bank.
- R11: When the host and the coprocessor write in the same cycle, only the host write is applied.
- R12: A `frame_start` while `list_en`=0 halts the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_en | input | 1 | Display list enable, sampled at frame start |
| frame_start | input | 1 | One-cycle frame-start pulse |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register offset |
| host_data | input | 8 | Host write data |
| cop_wr | input | 1 | Coprocessor move-instruction write strobe |
| cop_addr | input | 8 | Coprocessor register offset |
| cop_data | input | 8 | Coprocessor write data |
| advance | input | 1 | Instruction consumed, step forward |
| adv_words | input | 2 | Number of words to step forward |
| branch | input | 1 | Relative branch pulse |
| branch_off | input | 8 | Signed branch offset |
| end_list | input | 1 | End-of-list command pulse |
| fetch_addr | output | 19 | {bank, word address} for the next fetch |
| running | output | 1 | 1 while fetching is live |

## Verification
The address path is driven with forward steps of 1, 2 and 3 words and with a step across the 0xFFFF boundary, which separates a correct modulo wrap from a carry that leaks into the bank. Relative branches are applied with a positive and a negative offset, which shows whether the sign extension is correct. Jump strobes are written with bit 3 set, with bit 3 clear but nonzero low bits, and through the start strobe with every low bit set. These cases show whether the bank trigger is decoded from the right bit and from the right register. Simultaneous events (strobe with frame start, host with coprocessor, end-of-list followed by steps) check that the priorities are applied and that halted inputs are ignored.

// File: rtl/dlist_pkg.sv
package dlist_pkg;

    parameter int ADDR_W = 16;
    parameter int BANK_W = 3;
    parameter int REG_W  = 8;
    parameter int OFF_W  = 8;
    parameter int STEP_W = 2;
    localparam int FETCH_W = ADDR_W + BANK_W;

    // Register offsets. The jump pointer and jump strobe offsets are fixed
    // by the coprocessor move instruction encodings that target them.
    parameter logic [REG_W-1:0] OFS_START_LO = 8'h3E;
    parameter logic [REG_W-1:0] OFS_START_HI = 8'h3F;
    parameter logic [REG_W-1:0] OFS_START_GO = 8'h40;
    parameter logic [REG_W-1:0] OFS_JUMP_LO  = 8'h41;
    parameter logic [REG_W-1:0] OFS_JUMP_HI  = 8'h42;
    parameter logic [REG_W-1:0] OFS_JUMP_GO  = 8'h43;

    // Bit of the jump strobe value that requests a bank change.
    parameter int BANK_TRIG_BIT = 3;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_RESTART,
        ACT_JUMP,
        ACT_START_GO,
        ACT_BRANCH,
        ACT_STEP
    } pc_act_t;

    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } reg_wr_t;

endpackage

// File: rtl/dlist_regs.sv
module dlist_regs
    import dlist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_addr,
    input  logic [REG_W-1:0]  host_data,
    input  logic              cop_wr,
    input  logic [REG_W-1:0]  cop_addr,
    input  logic [REG_W-1:0]  cop_data,
    output logic [ADDR_W-1:0] start_ptr,
    output logic [ADDR_W-1:0] jump_ptr,
    output logic              jump_go,
    output logic [REG_W-1:0]  jump_val,
    output logic              start_go
);

    localparam int BYTES = ADDR_W / REG_W;

    reg_wr_t wsel;

    // Host has priority over the coprocessor on a shared cycle.
    always_comb begin
        if (host_wr) begin
            wsel.wr   = 1'b1;
            wsel.addr = host_addr;
            wsel.data = host_data;
        end else begin
            wsel.wr   = cop_wr;
            wsel.addr = cop_addr;
            wsel.data = cop_data;
        end
    end

    logic [BYTES-1:0] start_hit;
    logic [BYTES-1:0] jump_hit;

    always_comb begin
        start_hit = '0;
        jump_hit  = '0;
        if (wsel.wr) begin
            start_hit[0] = (wsel.addr == OFS_START_LO);
            start_hit[1] = (wsel.addr == OFS_START_HI);
            jump_hit[0]  = (wsel.addr == OFS_JUMP_LO);
            jump_hit[1]  = (wsel.addr == OFS_JUMP_HI);
        end
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_ptr[b*REG_W +: REG_W] <= '0;
                jump_ptr[b*REG_W +: REG_W]  <= '0;
            end else begin
                if (start_hit[b])
                    start_ptr[b*REG_W +: REG_W] <= wsel.data;
                if (jump_hit[b])
                    jump_ptr[b*REG_W +: REG_W] <= wsel.data;
            end
        end
    end

    assign jump_go  = wsel.wr && (wsel.addr == OFS_JUMP_GO);
    assign start_go = wsel.wr && (wsel.addr == OFS_START_GO);
    assign jump_val = wsel.data;

endmodule

// File: rtl/dlist_fsm.sv
module dlist_fsm
    import dlist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              list_en,
    input  logic              frame_start,
    input  logic              jump_go,
    input  logic              start_go,
    input  logic              end_list,
    input  logic              branch,
    input  logic              advance,
    output pc_act_t           act,
    output logic              running
);

    seq_state_t state_q;
    seq_state_t state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_HALT;
        else
            state_q <= state_d;
    end

    // Next state and action. Priority order: frame start, jump strobe,
    // start strobe, end of list, branch, step.
    always_comb begin
        state_d = state_q;
        act     = ACT_HOLD;
        unique case (state_q)
            ST_HALT: begin
                if (frame_start) begin
                    if (list_en) begin
                        state_d = ST_RUN;      // T_START
                        act     = ACT_RESTART;
                    end
                end else if (jump_go) begin
                    act = ACT_JUMP;
                end else if (start_go) begin
                    act = ACT_START_GO;
                end
            end
            ST_RUN: begin
                if (frame_start) begin
                    if (list_en) begin
                        act = ACT_RESTART;     // T_RESTART
                    end else begin
                        state_d = ST_HALT;     // T_DISABLE
                    end
                end else if (jump_go) begin
                    act = ACT_JUMP;
                end else if (start_go) begin
                    act = ACT_START_GO;
                end else if (end_list) begin
                    state_d = ST_HALT;         // T_STOP
                end else if (branch) begin
                    act = ACT_BRANCH;
                end else if (advance) begin
                    act = ACT_STEP;
                end
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase
    end

    // Output process.
    always_comb begin
        running = (state_q == ST_RUN);
    end

endmodule

// File: rtl/dlist_pc.sv
module dlist_pc
    import dlist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pc_act_t           act,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic [ADDR_W-1:0] jump_ptr,
    input  logic [REG_W-1:0]  jump_val,
    input  logic [OFF_W-1:0]  branch_off,
    input  logic [STEP_W-1:0] adv_words,
    output logic [FETCH_W-1:0] fetch_addr
);

    logic [ADDR_W-1:0] pc_q,   pc_d;
    logic [BANK_W-1:0] bank_q, bank_d;

    logic [ADDR_W-1:0] off_ext;
    assign off_ext = {{(ADDR_W-OFF_W){branch_off[OFF_W-1]}}, branch_off};

    always_comb begin
        pc_d   = pc_q;
        bank_d = bank_q;
        unique case (act)
            ACT_HOLD:     pc_d = pc_q;
            ACT_RESTART:  pc_d = start_ptr;
            ACT_JUMP: begin
                pc_d = jump_ptr;
                if (jump_val[BANK_TRIG_BIT])
                    bank_d = jump_val[BANK_W-1:0];
            end
            ACT_START_GO: pc_d = start_ptr;
            ACT_BRANCH:   pc_d = pc_q + off_ext;
            ACT_STEP:     pc_d = pc_q + ADDR_W'(adv_words);
            default:      pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            bank_q <= '0;
        end else begin
            pc_q   <= pc_d;
            bank_q <= bank_d;
        end
    end

    assign fetch_addr = {bank_q, pc_q};

endmodule

// File: rtl/dlist_seq.sv
module dlist_seq
    import dlist_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               list_en,
    input  logic               frame_start,
    input  logic               host_wr,
    input  logic [7:0]         host_addr,
    input  logic [7:0]         host_data,
    input  logic               cop_wr,
    input  logic [7:0]         cop_addr,
    input  logic [7:0]         cop_data,
    input  logic               advance,
    input  logic [1:0]         adv_words,
    input  logic               branch,
    input  logic [7:0]         branch_off,
    input  logic               end_list,
    output logic [18:0]        fetch_addr,
    output logic               running
);

    logic [ADDR_W-1:0] start_ptr;
    logic [ADDR_W-1:0] jump_ptr;
    logic              jump_go;
    logic              start_go;
    logic [REG_W-1:0]  jump_val;
    pc_act_t           act;

    dlist_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_data (host_data),
        .cop_wr    (cop_wr),
        .cop_addr  (cop_addr),
        .cop_data  (cop_data),
        .start_ptr (start_ptr),
        .jump_ptr  (jump_ptr),
        .jump_go   (jump_go),
        .jump_val  (jump_val),
        .start_go  (start_go)
    );

    dlist_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .list_en     (list_en),
        .frame_start (frame_start),
        .jump_go     (jump_go),
        .start_go    (start_go),
        .end_list    (end_list),
        .branch      (branch),
        .advance     (advance),
        .act         (act),
        .running     (running)
    );

    dlist_pc u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .start_ptr  (start_ptr),
        .jump_ptr   (jump_ptr),
        .jump_val   (jump_val),
        .branch_off (branch_off),
        .adv_words  (adv_words),
        .fetch_addr (fetch_addr)
    );

endmodule

// File: rtl/dlist_seq_chk.sv
module dlist_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        list_en,
    input logic        frame_start,
    input logic        advance,
    input logic [1:0]  adv_words,
    input logic        branch,
    input logic        end_list,
    input logic        jump_go,
    input logic        start_go,
    input logic [7:0]  jump_val,
    input logic [15:0] start_ptr,
    input logic [18:0] fetch_addr,
    input logic        running
);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && list_en) |=> (running && fetch_addr[15:0] == $past(start_ptr)));

    assert_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(frame_start && list_en));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && advance && !branch && !end_list && !frame_start && !jump_go && !start_go)
        |=> (fetch_addr[15:0] == 16'($past(fetch_addr[15:0]) + 16'($past(adv_words))))
            && $stable(fetch_addr[18:16]));

    assert_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fetch_addr[18:16]) |-> $past(jump_go && jump_val[3] && !frame_start));

    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && end_list && !frame_start && !jump_go && !start_go) |=> !running);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !frame_start && !jump_go && !start_go) |=> $stable(fetch_addr));

    assert_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !list_en) |=> !running);

endmodule

bind dlist_seq dlist_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .list_en     (list_en),
    .frame_start (frame_start),
    .advance     (advance),
    .adv_words   (adv_words),
    .branch      (branch),
    .end_list    (end_list),
    .jump_go     (jump_go),
    .start_go    (start_go),
    .jump_val    (jump_val),
    .start_ptr   (start_ptr),
    .fetch_addr  (fetch_addr),
    .running     (running)
);

// File: tb/sim_dlist_seq.sv
`timescale 1ns/1ps
module sim_dlist_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        list_en = 1'b0;
    logic        frame_start = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        cop_wr = 1'b0;
    logic [7:0]  cop_addr = '0;
    logic [7:0]  cop_data = '0;
    logic        advance = 1'b0;
    logic [1:0]  adv_words = '0;
    logic        branch = 1'b0;
    logic [7:0]  branch_off = '0;
    logic        end_list = 1'b0;
    logic [18:0] fetch_addr;
    logic        running;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dlist_seq u0 (
        .clk(clk), .rst_n(rst_n), .list_en(list_en), .frame_start(frame_start),
        .host_wr(host_wr), .host_addr(host_addr), .host_data(host_data),
        .cop_wr(cop_wr), .cop_addr(cop_addr), .cop_data(cop_data),
        .advance(advance), .adv_words(adv_words), .branch(branch),
        .branch_off(branch_off), .end_list(end_list),
        .fetch_addr(fetch_addr), .running(running)
    );

    task automatic check(input string req, input logic [18:0] exp_a, input logic exp_r);
        checks++;
        if (fetch_addr !== exp_a || running !== exp_r) begin
            errors++;
            $display("FAIL %s: addr=%05h run=%0b expected addr=%05h run=%0b",
                     req, fetch_addr, running, exp_a, exp_r);
        end
    endtask

    // Each stimulus task drives at a falling edge and releases at the next,
    // so exactly one rising edge sees it; results are sampled right after.
    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_data = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic cwrite(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cop_wr = 1; cop_addr = a; cop_data = d;
        @(negedge clk); cop_wr = 0;
    endtask

    task automatic frame(input logic en);
        @(negedge clk); list_en = en; frame_start = 1;
        @(negedge clk); frame_start = 0;
    endtask

    task automatic step(input logic [1:0] n);
        @(negedge clk); advance = 1; adv_words = n;
        @(negedge clk); advance = 0;
    endtask

    task automatic jump_rel(input logic [7:0] o);
        @(negedge clk); branch = 1; branch_off = o;
        @(negedge clk); branch = 0;
    endtask

    task automatic stop_list();
        @(negedge clk); end_list = 1;
        @(negedge clk); end_list = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset", 19'h00000, 1'b0);
        step(2'd2);
        check("R1 halted after reset", 19'h00000, 1'b0);
    endtask

    task automatic t_start();
        hwrite(8'h3E, 8'h34);
        hwrite(8'h3F, 8'h12);
        frame(1'b1);
        check("R2 frame start", 19'h01234, 1'b1);
    endtask

    task automatic t_step();
        step(2'd1); check("R3 step 1", 19'h01235, 1'b1);
        step(2'd3); check("R3 step 3", 19'h01238, 1'b1);
        step(2'd2); check("R3 step 2", 19'h0123A, 1'b1);
    endtask

    task automatic t_branch();
        jump_rel(8'h05); check("R4 branch +5", 19'h0123F, 1'b1);
        jump_rel(8'hFD); check("R4 branch -3", 19'h0123C, 1'b1);
    endtask

    task automatic t_wrap();
        hwrite(8'h3E, 8'hFE);
        hwrite(8'h3F, 8'hFF);
        hwrite(8'h40, 8'h00);
        check("R7 start strobe", 19'h0FFFE, 1'b1);
        step(2'd3);
        check("R3 wrap", 19'h00001, 1'b1);
    endtask

    task automatic t_jump();
        cwrite(8'h41, 8'h00);
        cwrite(8'h42, 8'h01);
        cwrite(8'h43, 8'h00);
        check("R5 jump strobe", 19'h00100, 1'b1);
        cwrite(8'h43, 8'h09);
        check("R6 jump with bank 1", 19'h10100, 1'b1);
        cwrite(8'h42, 8'h02);
        cwrite(8'h43, 8'h05);
        check("R6 bit3 clear keeps bank", 19'h10200, 1'b1);
        hwrite(8'h40, 8'h0F);
        check("R7 start strobe keeps bank", 19'h1FFFE, 1'b1);
    endtask

    task automatic t_persist();
        step(2'd1);
        check("R8 before frame", 19'h1FFFF, 1'b1);
        frame(1'b1);
        check("R8 bank kept at restart", 19'h1FFFE, 1'b1);
        hwrite(8'h3E, 8'h10);
        hwrite(8'h3F, 8'h00);
        frame(1'b1);
        check("R8 new start ptr", 19'h10010, 1'b1);
    endtask

    task automatic t_stop();
        stop_list();
        check("R9 end of list", 19'h10010, 1'b0);
        step(2'd3);
        check("R9 step ignored", 19'h10010, 1'b0);
        jump_rel(8'h40);
        check("R9 branch ignored", 19'h10010, 1'b0);
        frame(1'b1);
        check("R9 resume at frame", 19'h10010, 1'b1);
    endtask

    task automatic t_collide();
        @(negedge clk);
        frame_start = 1; list_en = 1;
        host_wr = 1; host_addr = 8'h43; host_data = 8'h0A;
        @(negedge clk);
        frame_start = 0; host_wr = 0;
        check("R10 frame beats strobe", 19'h10010, 1'b1);
        @(negedge clk);
        host_wr = 1; host_addr = 8'h41; host_data = 8'h33;
        cop_wr  = 1; cop_addr  = 8'h41; cop_data  = 8'h44;
        @(negedge clk);
        host_wr = 0; cop_wr = 0;
        hwrite(8'h43, 8'h00);
        check("R11 host wins", 19'h10233, 1'b1);
    endtask

    task automatic t_disable();
        frame(1'b0);
        check("R12 frame with list off", 19'h10233, 1'b0);
    endtask

    initial begin
        t_reset();
        t_start();
        t_step();
        t_branch();
        t_wrap();
        t_jump();
        t_persist();
        t_stop();
        t_collide();
        t_disable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule